// File: doc/BRIEF.md
# Run-Time Memory Width Converter

This block joins a 32-bit application data port to a memory data path that is 32, 16 or 8 bits wide. The width is a run-time input, so one netlist serves all three memory widths.

On the write side, the transfer controller strobes one memory beat per cycle. For each beat, the block presents the matching slice of the current application word and that slice's active-low byte enables. On the last beat of a word, it asks the application for the next word. On the read side, memory beats are collected into a 32-bit word, and the word is presented to the application with a one-cycle valid strobe.

Burst start markers restart the slice position on both paths. Burst last markers are passed to the application on both paths. Read data is registered once, and the write path is combinational from the transfer strobes.

Top module: `mwc_width_conv`

## Requirements
- R1: `width_sel_i` selects the memory width: 00 is 32-bit (1 beat per word), 01 is 16-bit (2 beats), and 10 or 11 is 8-bit (4 beats).
- R2: On a write beat, `mem_wr_data_o` carries slice k of the application word in its low bits, where slice 0 is the least significant. Slices go out in ascending order, and bits above the memory width are zero.
- R3: `mem_wr_be_no` carries the active-low enable bits of that same slice in its low bits. Enable bits above the memory width read 1, which means inactive.
- R4: `app_wr_next_o` is high in the same cycle as a write beat (`xfr_wr_next_i`) that ends a word, and low in every other cycle.
- R5: `xfr_wr_start_i` forces the slice position to 0 for the beat in that cycle, so a partly sent word is abandoned.
- R6: A write beat with `xfr_wr_last_i` raises `app_wr_last_o` and `app_wr_next_o`. The next beat starts again at slice 0.
- R7: On a read beat (`xfr_rd_ok_i`), the low memory-width bits of `mem_rd_data_i` fill slice k of the word, starting from the least significant slice. Upper input bits are ignored. The completed word appears on `app_rd_data_o`, with `app_rd_valid_o` high for one cycle, in the cycle after the completing beat.
- R8: `app_rd_valid_o` stays low after any beat that does not complete a word.
- R9: `xfr_rd_start_i` discards any partly gathered word. The beat in that cycle fills slice 0.
- R10: A read beat with `xfr_rd_last_i` completes the word early, with missing slices read as zero. It raises `app_rd_last_o` together with the valid strobe.
- R11: During reset and right after it, `app_rd_valid_o`, `app_rd_last_o`, `app_wr_next_o` and `app_wr_last_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| width_sel_i | input | 2 | Memory width select |
| app_wr_data_i | input | 32 | Application write word |
| app_wr_be_ni | input | 4 | Application byte enables, active low |
| app_wr_next_o | output | 1 | Request for the next write word |
| app_wr_last_o | output | 1 | Last write beat of the burst |
| app_rd_data_o | output | 32 | Assembled read word |
| app_rd_valid_o | output | 1 | Read word valid strobe |
| app_rd_last_o | output | 1 | Last read word of the burst |
| xfr_wr_start_i | input | 1 | Write burst start |
| xfr_wr_next_i | input | 1 | Memory write beat taken |
| xfr_wr_last_i | input | 1 | Final write beat of the burst |
| mem_wr_data_o | output | 32 | Write slice toward memory |
| mem_wr_be_no | output | 4 | Write slice byte enables, active low |
| xfr_rd_start_i | input | 1 | Read burst start |
| xfr_rd_ok_i | input | 1 | Memory read beat valid |
| xfr_rd_last_i | input | 1 | Final read beat of the burst |
| mem_rd_data_i | input | 32 | Read beat from memory |

## Verification
The bench uses the default parameters: 8-bit bytes and a 4-byte word. With these, the three run-time widths cover beat counts of 1, 2 and 4. Both select codes for the 8-bit width are exercised, and so is each slice index within a word. Read beats carry garbage above the memory width to show that those bits are ignored. Directed cases cover a start arriving mid-word, a last marker that cuts a word short, and words that follow each other back to back inside one burst.

// File: rtl/mwc_pkg.sv
package mwc_pkg;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned WORD_BYTES = 4;

  typedef enum logic [1:0] {
    MW_FULL = 2'd0,
    MW_HALF = 2'd1,
    MW_BYTE = 2'd2
  } mem_width_e;

  function automatic mem_width_e decode_width(input logic [1:0] sel);
    if (sel[1]) return MW_BYTE;
    if (sel[0]) return MW_HALF;
    return MW_FULL;
  endfunction
endpackage

// File: rtl/mwc_width_dec.sv
module mwc_width_dec
  import mwc_pkg::*;
#(
  parameter int unsigned WORD_BYTES = mwc_pkg::WORD_BYTES,
  localparam int unsigned IDX_W = $clog2(WORD_BYTES),
  localparam int unsigned SH_W  = $clog2(IDX_W + 1)
) (
  input  logic [1:0]       sel_i,
  output logic [SH_W-1:0]  shift_o,
  output logic [IDX_W-1:0] last_idx_o
);
  mem_width_e mode;
  int unsigned sh;

  always_comb begin
    mode = decode_width(sel_i);
    case (mode)
      MW_FULL: sh = IDX_W;
      MW_HALF: sh = IDX_W - 1;
      default: sh = 0;
    endcase
    shift_o    = SH_W'(sh);
    last_idx_o = IDX_W'((1 << (IDX_W - sh)) - 1);
  end
endmodule

// File: rtl/mwc_wr_split.sv
module mwc_wr_split #(
  parameter int unsigned BYTE_W     = 8,
  parameter int unsigned WORD_BYTES = 4,
  localparam int unsigned DW    = BYTE_W * WORD_BYTES,
  localparam int unsigned IDX_W = $clog2(WORD_BYTES),
  localparam int unsigned SH_W  = $clog2(IDX_W + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [SH_W-1:0]       shift_i,
  input  logic [IDX_W-1:0]      last_idx_i,
  input  logic                  start_i,
  input  logic                  next_i,
  input  logic                  last_i,
  input  logic [DW-1:0]         data_i,
  input  logic [WORD_BYTES-1:0] be_ni,
  output logic [DW-1:0]         mem_data_o,
  output logic [WORD_BYTES-1:0] mem_be_no,
  output logic                  app_next_o,
  output logic                  app_last_o
);
  logic [IDX_W-1:0] cnt_q, eff_idx, base_idx;
  logic [IDX_W:0]   bpb;
  logic             word_end;

  assign eff_idx  = start_i ? '0 : cnt_q;
  assign word_end = (eff_idx >= last_idx_i) | last_i;
  assign bpb      = (IDX_W+1)'(1) << shift_i;
  assign base_idx = eff_idx << shift_i;

  assign app_next_o = next_i & word_end;
  assign app_last_o = next_i & last_i;

  for (genvar b = 0; b < WORD_BYTES; b++) begin : g_byte
    logic [IDX_W-1:0] src;
    logic             used;
    assign src  = base_idx + IDX_W'(b);
    assign used = (IDX_W+1)'(b) < bpb;
    assign mem_data_o[b*BYTE_W +: BYTE_W] = used ? data_i[src*BYTE_W +: BYTE_W] : '0;
    assign mem_be_no[b] = used ? be_ni[src] : 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (next_i) begin
      cnt_q <= word_end ? '0 : eff_idx + 1'b1;
    end else if (start_i) begin
      cnt_q <= '0;
    end
  end
endmodule

// File: rtl/mwc_rd_pack.sv
module mwc_rd_pack #(
  parameter int unsigned BYTE_W     = 8,
  parameter int unsigned WORD_BYTES = 4,
  localparam int unsigned DW    = BYTE_W * WORD_BYTES,
  localparam int unsigned IDX_W = $clog2(WORD_BYTES),
  localparam int unsigned SH_W  = $clog2(IDX_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SH_W-1:0]  shift_i,
  input  logic [IDX_W-1:0] last_idx_i,
  input  logic             start_i,
  input  logic             ok_i,
  input  logic             last_i,
  input  logic [DW-1:0]    mem_data_i,
  output logic [DW-1:0]    word_o,
  output logic             valid_o,
  output logic             last_o
);
  logic [IDX_W-1:0] cnt_q, eff_idx, off_mask;
  logic [DW-1:0]    shadow_q, base, merged;
  logic             done;

  assign eff_idx  = start_i ? '0 : cnt_q;
  assign base     = start_i ? '0 : shadow_q;
  assign off_mask = IDX_W'(((IDX_W+1)'(1) << shift_i) - 1'b1);
  assign done     = ok_i & ((eff_idx >= last_idx_i) | last_i);

  for (genvar k = 0; k < WORD_BYTES; k++) begin : g_byte
    logic [IDX_W-1:0] slot, off;
    assign slot = IDX_W'(k) >> shift_i;
    assign off  = IDX_W'(k) & off_mask;
    assign merged[k*BYTE_W +: BYTE_W] = (ok_i && slot == eff_idx)
                                        ? mem_data_i[off*BYTE_W +: BYTE_W]
                                        : base[k*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      shadow_q <= '0;
      word_o   <= '0;
      valid_o  <= 1'b0;
      last_o   <= 1'b0;
    end else begin
      valid_o <= done;
      last_o  <= done & last_i;
      if (done) begin
        word_o   <= merged;
        shadow_q <= '0;
        cnt_q    <= '0;
      end else if (ok_i) begin
        shadow_q <= merged;
        cnt_q    <= eff_idx + 1'b1;
      end else if (start_i) begin
        shadow_q <= '0;
        cnt_q    <= '0;
      end
    end
  end
endmodule

// File: rtl/mwc_width_conv.sv
module mwc_width_conv
  import mwc_pkg::*;
#(
  parameter int unsigned BYTE_W     = mwc_pkg::BYTE_W,
  parameter int unsigned WORD_BYTES = mwc_pkg::WORD_BYTES,
  localparam int unsigned DW    = BYTE_W * WORD_BYTES,
  localparam int unsigned IDX_W = $clog2(WORD_BYTES),
  localparam int unsigned SH_W  = $clog2(IDX_W + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [1:0]            width_sel_i,
  input  logic [DW-1:0]         app_wr_data_i,
  input  logic [WORD_BYTES-1:0] app_wr_be_ni,
  output logic                  app_wr_next_o,
  output logic                  app_wr_last_o,
  output logic [DW-1:0]         app_rd_data_o,
  output logic                  app_rd_valid_o,
  output logic                  app_rd_last_o,
  input  logic                  xfr_wr_start_i,
  input  logic                  xfr_wr_next_i,
  input  logic                  xfr_wr_last_i,
  output logic [DW-1:0]         mem_wr_data_o,
  output logic [WORD_BYTES-1:0] mem_wr_be_no,
  input  logic                  xfr_rd_start_i,
  input  logic                  xfr_rd_ok_i,
  input  logic                  xfr_rd_last_i,
  input  logic [DW-1:0]         mem_rd_data_i
);
  logic [SH_W-1:0]  shift;
  logic [IDX_W-1:0] last_idx;

  mwc_width_dec #(.WORD_BYTES(WORD_BYTES)) u_dec (
    .sel_i      (width_sel_i),
    .shift_o    (shift),
    .last_idx_o (last_idx)
  );

  mwc_wr_split #(.BYTE_W(BYTE_W), .WORD_BYTES(WORD_BYTES)) u_wr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .shift_i    (shift),
    .last_idx_i (last_idx),
    .start_i    (xfr_wr_start_i),
    .next_i     (xfr_wr_next_i),
    .last_i     (xfr_wr_last_i),
    .data_i     (app_wr_data_i),
    .be_ni      (app_wr_be_ni),
    .mem_data_o (mem_wr_data_o),
    .mem_be_no  (mem_wr_be_no),
    .app_next_o (app_wr_next_o),
    .app_last_o (app_wr_last_o)
  );

  mwc_rd_pack #(.BYTE_W(BYTE_W), .WORD_BYTES(WORD_BYTES)) u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .shift_i    (shift),
    .last_idx_i (last_idx),
    .start_i    (xfr_rd_start_i),
    .ok_i       (xfr_rd_ok_i),
    .last_i     (xfr_rd_last_i),
    .mem_data_i (mem_rd_data_i),
    .word_o     (app_rd_data_o),
    .valid_o    (app_rd_valid_o),
    .last_o     (app_rd_last_o)
  );
endmodule

// File: rtl/mwc_width_conv_chk.sv
module mwc_width_conv_chk #(
  parameter int unsigned DW = 32,
  parameter int unsigned WB = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [1:0]    width_sel_i,
  input logic          xfr_wr_next_i,
  input logic          xfr_rd_ok_i,
  input logic          app_wr_next_o,
  input logic          app_wr_last_o,
  input logic          app_rd_valid_o,
  input logic          app_rd_last_o,
  input logic [DW-1:0] mem_wr_data_o,
  input logic [WB-1:0] mem_wr_be_no
);
  AST_RD_VALID_AFTER_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    app_rd_valid_o |-> $past(xfr_rd_ok_i)); // R8
  AST_RD_LAST_WITH_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    app_rd_last_o |-> app_rd_valid_o); // R10
  AST_WR_NEXT_FULL_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfr_wr_next_i && width_sel_i == 2'b00) |-> app_wr_next_o); // R4
  AST_WR_NEXT_NEEDS_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    app_wr_next_o |-> xfr_wr_next_i); // R4
  AST_WR_LAST_ENDS_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    app_wr_last_o |-> app_wr_next_o); // R6
  AST_BE_UPPER_IDLE_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    width_sel_i[1] |-> (&mem_wr_be_no[WB-1:1])); // R3
  AST_DATA_UPPER_ZERO_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (width_sel_i == 2'b01) |-> (mem_wr_data_o[DW-1:DW/2] == '0)); // R2
endmodule

bind mwc_width_conv mwc_width_conv_chk #(.DW(DW), .WB(WORD_BYTES)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .width_sel_i    (width_sel_i),
  .xfr_wr_next_i  (xfr_wr_next_i),
  .xfr_rd_ok_i    (xfr_rd_ok_i),
  .app_wr_next_o  (app_wr_next_o),
  .app_wr_last_o  (app_wr_last_o),
  .app_rd_valid_o (app_rd_valid_o),
  .app_rd_last_o  (app_rd_last_o),
  .mem_wr_data_o  (mem_wr_data_o),
  .mem_wr_be_no   (mem_wr_be_no)
);

// File: tb/mwc_width_conv_tb.sv
module mwc_width_conv_tb;
  timeunit 1ns; timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  width_sel_i = 2'b00;
  logic [31:0] app_wr_data_i = '0;
  logic [3:0]  app_wr_be_ni = 4'hF;
  logic        app_wr_next_o, app_wr_last_o;
  logic [31:0] app_rd_data_o;
  logic        app_rd_valid_o, app_rd_last_o;
  logic        xfr_wr_start_i = 1'b0, xfr_wr_next_i = 1'b0, xfr_wr_last_i = 1'b0;
  logic [31:0] mem_wr_data_o;
  logic [3:0]  mem_wr_be_no;
  logic        xfr_rd_start_i = 1'b0, xfr_rd_ok_i = 1'b0, xfr_rd_last_i = 1'b0;
  logic [31:0] mem_rd_data_i = '0;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  mwc_width_conv u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .width_sel_i(width_sel_i),
    .app_wr_data_i(app_wr_data_i), .app_wr_be_ni(app_wr_be_ni),
    .app_wr_next_o(app_wr_next_o), .app_wr_last_o(app_wr_last_o),
    .app_rd_data_o(app_rd_data_o), .app_rd_valid_o(app_rd_valid_o),
    .app_rd_last_o(app_rd_last_o),
    .xfr_wr_start_i(xfr_wr_start_i), .xfr_wr_next_i(xfr_wr_next_i),
    .xfr_wr_last_i(xfr_wr_last_i), .mem_wr_data_o(mem_wr_data_o),
    .mem_wr_be_no(mem_wr_be_no),
    .xfr_rd_start_i(xfr_rd_start_i), .xfr_rd_ok_i(xfr_rd_ok_i),
    .xfr_rd_last_i(xfr_rd_last_i), .mem_rd_data_i(mem_rd_data_i)
  );

  // {width_sel, word, byte enables}
  localparam logic [37:0] VEC [8] = '{
    {2'b00, 32'h1234_5678, 4'b0000},
    {2'b00, 32'hDEAD_BEEF, 4'b1010},
    {2'b01, 32'hA1B2_C3D4, 4'b0110},
    {2'b01, 32'h0F0F_F0F0, 4'b1100},
    {2'b10, 32'h8899_AABB, 4'b0011},
    {2'b11, 32'h1357_9BDF, 4'b0101},
    {2'b10, 32'hCAFE_F00D, 4'b1111},
    {2'b11, 32'h0000_0001, 4'b1000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int beats_of(input logic [1:0] sel);
    return sel[1] ? 4 : (sel[0] ? 2 : 1);
  endfunction

  function automatic logic [31:0] dslice(input logic [31:0] w, input int i, input int bpb);
    logic [63:0] m;
    m = (64'd1 << (bpb*8)) - 1;
    return 32'(({32'd0, w} >> (i*bpb*8)) & m);
  endfunction

  function automatic logic [3:0] bslice(input logic [3:0] be, input int i, input int bpb);
    logic [3:0] m;
    m = 4'((5'd1 << bpb) - 1);
    return (~m) | ((be >> (i*bpb)) & m);
  endfunction

  task automatic idle();
    xfr_wr_start_i = 0; xfr_wr_next_i = 0; xfr_wr_last_i = 0;
    xfr_rd_start_i = 0; xfr_rd_ok_i = 0; xfr_rd_last_i = 0;
  endtask

  task automatic rd_beat(input logic st, input logic lst, input logic [31:0] d);
    @(negedge clk);
    idle();
    xfr_rd_start_i = st; xfr_rd_ok_i = 1; xfr_rd_last_i = lst; mem_rd_data_i = d;
    @(posedge clk); #1;
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R11 rd_valid in reset", 32'(app_rd_valid_o), 0);
    chk("R11 rd_last in reset", 32'(app_rd_last_o), 0);
    @(negedge clk); rst_ni = 1;
    @(posedge clk); #1;
    chk("R11 rd_valid after reset", 32'(app_rd_valid_o), 0);
    chk("R11 wr_next after reset", 32'(app_wr_next_o), 0);
    chk("R11 wr_last after reset", 32'(app_wr_last_o), 0);

    // Table walk: every entry is a one-word burst on each path (R1, R2, R3, R4, R7, R8, R10)
    for (int v = 0; v < 8; v++) begin
      logic [1:0]  sel;
      logic [31:0] w;
      logic [3:0]  be;
      int nb, bpb;
      {sel, w, be} = VEC[v];
      nb = beats_of(sel);
      bpb = 4 / nb;
      for (int i = 0; i < nb; i++) begin
        @(negedge clk);
        idle();
        width_sel_i = sel; app_wr_data_i = w; app_wr_be_ni = be;
        xfr_wr_start_i = (i == 0); xfr_wr_next_i = 1; xfr_wr_last_i = (i == nb-1);
        #1;
        chk("R2 write slice data", mem_wr_data_o, dslice(w, i, bpb));
        chk("R3 write slice enables", 32'(mem_wr_be_no), 32'(bslice(be, i, bpb)));
        chk("R4 next-word request", 32'(app_wr_next_o), 32'(i == nb-1));
        chk("R6 write last flag", 32'(app_wr_last_o), 32'(i == nb-1));
      end
      for (int i = 0; i < nb; i++) begin
        // junk above the memory width must be ignored (R7)
        rd_beat(i == 0, i == nb-1, (32'hFFFF_FFFF & ~((32'hFFFF_FFFF >> (32 - bpb*8)))) | dslice(w, i, bpb));
        if (i == nb-1) begin
          chk("R7 read word assembled", app_rd_data_o, w);
          chk("R7 read valid on full word", 32'(app_rd_valid_o), 1);
          chk("R10 read last with word", 32'(app_rd_last_o), 1);
        end else begin
          chk("R8 no valid on partial word", 32'(app_rd_valid_o), 0);
        end
      end
    end

    // R7: two words back to back in one 16-bit burst, no start on the second
    width_sel_i = 2'b01;
    rd_beat(1, 0, 32'h0000_2211);
    rd_beat(0, 0, 32'h0000_4433);
    chk("R7 first word of burst", app_rd_data_o, 32'h4433_2211);
    chk("R10 no last mid burst", 32'(app_rd_last_o), 0);
    rd_beat(0, 0, 32'h0000_6655);
    chk("R8 partial second word", 32'(app_rd_valid_o), 0);
    rd_beat(0, 1, 32'h0000_8877);
    chk("R7 second word of burst", app_rd_data_o, 32'h8877_6655);

    // R9: start discards a partial 8-bit word
    width_sel_i = 2'b10;
    rd_beat(1, 0, 32'h0000_0011);
    rd_beat(0, 0, 32'h0000_0022);
    rd_beat(1, 0, 32'h0000_0044);
    chk("R9 no valid after restart beat", 32'(app_rd_valid_o), 0);
    rd_beat(0, 0, 32'h0000_0055);
    rd_beat(0, 0, 32'h0000_0066);
    rd_beat(0, 1, 32'h0000_0077);
    chk("R9 restarted word", app_rd_data_o, 32'h7766_5544);

    // R10: last on the first half of a 16-bit word pads with zero
    width_sel_i = 2'b01;
    rd_beat(1, 1, 32'h5A5A_BEEF);
    chk("R10 short word padded", app_rd_data_o, 32'h0000_BEEF);
    chk("R10 short word valid", 32'(app_rd_valid_o), 1);
    chk("R10 short word last", 32'(app_rd_last_o), 1);
    @(negedge clk); idle(); @(posedge clk); #1;
    chk("R8 valid is one cycle", 32'(app_rd_valid_o), 0);

    // R5: write start mid-word restarts at slice 0
    @(negedge clk); idle();
    width_sel_i = 2'b10; app_wr_data_i = 32'h4433_2211; app_wr_be_ni = 4'b0110;
    xfr_wr_start_i = 1; xfr_wr_next_i = 1;
    @(negedge clk); xfr_wr_start_i = 0; #1;
    chk("R2 second byte slice", mem_wr_data_o, 32'h0000_0022);
    chk("R3 second byte enable", 32'(mem_wr_be_no), 32'hF);
    @(negedge clk); xfr_wr_start_i = 1; #1;
    chk("R5 restart at slice 0", mem_wr_data_o, 32'h0000_0011);
    chk("R5 no next on restart", 32'(app_wr_next_o), 0);

    // R6: last on a non-final beat ends the word, next beat is slice 0
    @(negedge clk); xfr_wr_start_i = 0; xfr_wr_last_i = 1; #1;
    chk("R6 early last data", mem_wr_data_o, 32'h0000_0022);
    chk("R6 early last next", 32'(app_wr_next_o), 1);
    chk("R6 early last flag", 32'(app_wr_last_o), 1);
    @(negedge clk); xfr_wr_last_i = 0; #1;
    chk("R6 slice 0 after last", mem_wr_data_o, 32'h0000_0011);

    // R4: no request without a beat
    @(negedge clk); idle(); width_sel_i = 2'b00; #1;
    chk("R4 no next when idle", 32'(app_wr_next_o), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule